// File: doc/BRIEF.md
# Disk DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both the host controller and an attached disk drive support. It takes the capability masks reported by the drive for its three DMA classes (Ultra, multiword and single-word), the validity flags that say which of those words can be trusted, and a legacy single-word timing number. It also takes the host's own capability masks, a cable-quality flag, the mode that software asked for, and an inhibit that blocks DMA for non-disk devices on hosts that cannot run them.

Mode codes are eight bits wide. Single-word modes start at 0x10, multiword modes at 0x20 and Ultra modes at 0x40, and the low bits give the mode number within its class. The classes are tried from fastest to slowest. The first class whose common mask is nonzero supplies its highest mode, and that result is then limited to the requested mode. Software pulses a request strobe, and one cycle later the block presents the chosen code together with a one-cycle valid pulse. Issuing the resulting mode to the drive is left to other logic.

Top module: `dma_mode_sel`

## Requirements
- R1: After reset `vld_o` is 0 and `mode_o` is 0x00.
- R2: A high `req_i` sampled at a clock edge makes `vld_o` high for exactly the next cycle, with `mode_o` carrying the result for the inputs sampled at that edge. Without a strobe, `vld_o` is low and `mode_o` keeps its last value whatever the inputs do.
- R3: The Ultra mask is `host_udma_i & drv_udma_i`. It takes part only when `id_valid_i[2]` is 1 and is treated as zero otherwise.
- R4: The multiword mask is `host_mword_i & drv_mword_i`. When `id_valid_i[1]` is 1, the single-word mask is `host_sword_i & drv_sword_i`. The multiword mask is zero when `id_valid_i[1]` is 0.
- R5: When `id_valid_i[1]` is 0 and `drv_legacy_i` is 2 or less, the single-word mask has bits 0 through `drv_legacy_i` set, ANDed with `host_sword_i`. A larger legacy value gives an empty single-word mask.
- R6: When the requested mode is above 0x42, the Ultra mask has any of bits 3 to 6 set, and `cable_ok_i` is 0, the Ultra mask is cut down to its bits 0 to 2.
- R7: The classes are tried in the order Ultra, multiword, single-word. The first class with a nonzero mask wins, and its mode is the class base code plus the index of its highest set mask bit.
- R8: A class is skipped when the requested mode is below its base code (0x40 Ultra, 0x20 multiword, 0x10 single-word).
- R9: The reported mode is the smaller of the winning mode and `req_mode_i`.
- R10: When `non_disk_i` and `host_no_atapi_dma_i` are both 1, the result is 0x00 regardless of the masks.
- R11: When no class yields a mode, the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one evaluation per high cycle |
| req_mode_i | input | 8 | Requested (ceiling) mode code |
| id_valid_i | input | 3 | Drive word validity; bit 2 Ultra, bit 1 multi/single-word, bit 0 unused |
| drv_udma_i | input | UDMA_W (7) | Drive Ultra modes supported |
| drv_mword_i | input | MW_W (3) | Drive multiword modes supported |
| drv_sword_i | input | SW_W (3) | Drive single-word modes supported |
| drv_legacy_i | input | LEG_W (8) | Drive legacy single-word timing mode number |
| host_udma_i | input | UDMA_W (7) | Host Ultra modes supported |
| host_mword_i | input | MW_W (3) | Host multiword modes supported |
| host_sword_i | input | SW_W (3) | Host single-word modes supported |
| cable_ok_i | input | 1 | Cable fit for Ultra modes above 2 |
| non_disk_i | input | 1 | Attached device is not a disk |
| host_no_atapi_dma_i | input | 1 | Host refuses DMA for non-disk devices |
| vld_o | output | 1 | One-cycle result valid pulse |
| mode_o | output | 8 | Selected mode code, 0x00 for none |

## Verification
Directed patterns isolate one rule at a time. Ultra masks that differ between host and drive show the AND. Clearing each validity bit shows which class drops out and which one takes over. The legacy timing values 1 and 3 sit on either side of the limit. For the cable rule, requested modes 0x42 and 0x43 are paired with the cable flag in both states, and an Ultra mask holding only high bits shows the fall-through to multiword after the cut. Requested modes of 0x41, 0x30, 0x22, 0x15 and 0x0F tell apart skipping a class from clamping its result. All four inhibit combinations show that only the joint case forces zero. Random masks, validity bits, legacy values and requested modes near the class bases are then checked against a bench model of the priority search.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

   localparam int MODE_W = 8;

   typedef enum logic [1:0] {
      CLS_SWORD = 2'd0,
      CLS_MWORD = 2'd1,
      CLS_ULTRA = 2'd2
   } xfer_cls_e;

   localparam logic [MODE_W-1:0] SWORD_BASE = 8'h10;
   localparam logic [MODE_W-1:0] MWORD_BASE = 8'h20;
   localparam logic [MODE_W-1:0] ULTRA_BASE = 8'h40;

   // Highest Ultra mode index usable without a qualified cable
   localparam int ULTRA_SAFE_TOP = 2;

   function automatic logic [MODE_W-1:0] cls_base(input xfer_cls_e c);
      case (c)
         CLS_ULTRA: cls_base = ULTRA_BASE;
         CLS_MWORD: cls_base = MWORD_BASE;
         default:   cls_base = SWORD_BASE;
      endcase
   endfunction

endpackage

// File: rtl/dmasel_msb.sv
module dmasel_msb #(
   parameter  int W  = 7,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("dmasel_msb: W must be at least 1");
      end
   endgenerate

   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/dmasel_cls_mask.sv
module dmasel_cls_mask
   import dmasel_pkg::*;
#(
   parameter xfer_cls_e CLS   = CLS_ULTRA,
   parameter int        W     = 7,
   parameter int        LEG_W = 8
) (
   input  logic [W-1:0]      drv_mask_i,
   input  logic [W-1:0]      host_mask_i,
   input  logic              word_ok_i,
   input  logic [LEG_W-1:0]  legacy_i,
   input  logic [MODE_W-1:0] req_mode_i,
   input  logic              cable_ok_i,
   output logic [W-1:0]      mask_o
);

   logic [W-1:0] common;

   assign common = word_ok_i ? (host_mask_i & drv_mask_i) : '0;

   generate
      if (CLS == CLS_ULTRA) begin : g_ultra
         localparam int LOW_BITS = ULTRA_SAFE_TOP + 1;
         localparam logic [W-1:0] LOW_KEEP = W'((1 << LOW_BITS) - 1);
         localparam logic [MODE_W-1:0] FAST_LIMIT =
            ULTRA_BASE + MODE_W'(ULTRA_SAFE_TOP);

         if (W <= LOW_BITS) begin : g_bad_w
            $error("dmasel_cls_mask: Ultra width too small for cable rule");
         end

         logic fast_req;
         logic fast_bits;
         logic cut;

         assign fast_req  = req_mode_i > FAST_LIMIT;
         assign fast_bits = |(common & ~LOW_KEEP);
         assign cut       = fast_req && fast_bits && !cable_ok_i;
         assign mask_o    = cut ? (common & LOW_KEEP) : common;

         logic unused_ultra;
         assign unused_ultra = ^legacy_i;
      end else if (CLS == CLS_MWORD) begin : g_mword
         assign mask_o = common;

         logic unused_mword;
         assign unused_mword = ^{legacy_i, req_mode_i, cable_ok_i};
      end else begin : g_sword
         localparam logic [LEG_W-1:0] LEG_TOP = LEG_W'(W - 1);

         logic [W-1:0] legacy_mask;

         always_comb begin
            legacy_mask = '0;
            if (legacy_i <= LEG_TOP) begin
               for (int i = 0; i < W; i++) begin
                  if (LEG_W'(i) <= legacy_i) legacy_mask[i] = 1'b1;
               end
            end
         end

         // R5: legacy timing is the fallback when the word is not valid
         assign mask_o = word_ok_i ? common : (legacy_mask & host_mask_i);

         logic unused_sword;
         assign unused_sword = ^{req_mode_i, cable_ok_i};
      end
   endgenerate

endmodule

// File: rtl/dmasel_cls_pick.sv
module dmasel_cls_pick
   import dmasel_pkg::*;
#(
   parameter xfer_cls_e CLS   = CLS_ULTRA,
   parameter int        W     = 7,
   parameter int        LEG_W = 8
) (
   input  logic [W-1:0]      drv_mask_i,
   input  logic [W-1:0]      host_mask_i,
   input  logic              word_ok_i,
   input  logic [LEG_W-1:0]  legacy_i,
   input  logic [MODE_W-1:0] req_mode_i,
   input  logic              cable_ok_i,
   output logic              hit_o,
   output logic [MODE_W-1:0] mode_o
);

   localparam int IW = (W > 1) ? $clog2(W) : 1;
   localparam logic [MODE_W-1:0] BASE = cls_base(CLS);

   logic [W-1:0]  mask;
   logic          any;
   logic [IW-1:0] idx;
   logic          reach;

   dmasel_cls_mask #(
      .CLS   (CLS),
      .W     (W),
      .LEG_W (LEG_W)
   ) mask_i (
      .drv_mask_i  (drv_mask_i),
      .host_mask_i (host_mask_i),
      .word_ok_i   (word_ok_i),
      .legacy_i    (legacy_i),
      .req_mode_i  (req_mode_i),
      .cable_ok_i  (cable_ok_i),
      .mask_o      (mask)
   );

   dmasel_msb #(
      .W (W)
   ) msb_i (
      .vec_i (mask),
      .any_o (any),
      .idx_o (idx)
   );

   // R8: a class below the request ceiling's reach is skipped
   assign reach  = req_mode_i >= BASE;
   assign hit_o  = reach && any;
   assign mode_o = BASE + MODE_W'(idx);

endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
   import dmasel_pkg::*;
#(
   parameter int UDMA_W = 7,
   parameter int MW_W   = 3,
   parameter int SW_W   = 3,
   parameter int LEG_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [7:0]        req_mode_i,
   input  logic [2:0]        id_valid_i,
   input  logic [UDMA_W-1:0] drv_udma_i,
   input  logic [MW_W-1:0]   drv_mword_i,
   input  logic [SW_W-1:0]   drv_sword_i,
   input  logic [LEG_W-1:0]  drv_legacy_i,
   input  logic [UDMA_W-1:0] host_udma_i,
   input  logic [MW_W-1:0]   host_mword_i,
   input  logic [SW_W-1:0]   host_sword_i,
   input  logic              cable_ok_i,
   input  logic              non_disk_i,
   input  logic              host_no_atapi_dma_i,
   output logic              vld_o,
   output logic [7:0]        mode_o
);

   localparam int NCLS = 3;
   localparam logic [MODE_W-1:0] CUT_CEIL = ULTRA_BASE + MODE_W'(ULTRA_SAFE_TOP);

   generate
      if (UDMA_W < ULTRA_SAFE_TOP + 2 || UDMA_W > 16) begin : g_bad_udma
         $error("dma_mode_sel: UDMA_W out of range");
      end
      if (MW_W < 1 || MW_W > 16) begin : g_bad_mw
         $error("dma_mode_sel: MW_W out of range");
      end
      if (SW_W < 1 || SW_W > 16) begin : g_bad_sw
         $error("dma_mode_sel: SW_W out of range");
      end
      if (LEG_W < 2) begin : g_bad_leg
         $error("dma_mode_sel: LEG_W too small");
      end
   endgenerate

   // Index 0 is the highest priority class
   logic [NCLS-1:0]   hit;
   logic [MODE_W-1:0] cand [NCLS];

   logic unused_valid0;
   assign unused_valid0 = id_valid_i[0];

   // R3: Ultra word trusted only with validity bit 2
   dmasel_cls_pick #(
      .CLS   (CLS_ULTRA),
      .W     (UDMA_W),
      .LEG_W (LEG_W)
   ) ultra_i (
      .drv_mask_i  (drv_udma_i),
      .host_mask_i (host_udma_i),
      .word_ok_i   (id_valid_i[2]),
      .legacy_i    (drv_legacy_i),
      .req_mode_i  (req_mode_i),
      .cable_ok_i  (cable_ok_i),
      .hit_o       (hit[0]),
      .mode_o      (cand[0])
   );

   // R4: multiword and single-word words need validity bit 1
   dmasel_cls_pick #(
      .CLS   (CLS_MWORD),
      .W     (MW_W),
      .LEG_W (LEG_W)
   ) mword_i (
      .drv_mask_i  (drv_mword_i),
      .host_mask_i (host_mword_i),
      .word_ok_i   (id_valid_i[1]),
      .legacy_i    (drv_legacy_i),
      .req_mode_i  (req_mode_i),
      .cable_ok_i  (cable_ok_i),
      .hit_o       (hit[1]),
      .mode_o      (cand[1])
   );

   dmasel_cls_pick #(
      .CLS   (CLS_SWORD),
      .W     (SW_W),
      .LEG_W (LEG_W)
   ) sword_i (
      .drv_mask_i  (drv_sword_i),
      .host_mask_i (host_sword_i),
      .word_ok_i   (id_valid_i[1]),
      .legacy_i    (drv_legacy_i),
      .req_mode_i  (req_mode_i),
      .cable_ok_i  (cable_ok_i),
      .hit_o       (hit[2]),
      .mode_o      (cand[2])
   );

   // R7: first hitting class in priority order wins
   logic [MODE_W-1:0] winner;
   always_comb begin
      winner = '0;
      for (int c = NCLS - 1; c >= 0; c--) begin
         if (hit[c]) winner = cand[c];
      end
   end

   // R9, R10, R11: clamp, inhibit, empty result
   logic              inhibit;
   logic [MODE_W-1:0] result;

   assign inhibit = non_disk_i && host_no_atapi_dma_i;

   always_comb begin
      if (inhibit)                 result = '0;
      else if (winner > req_mode_i) result = req_mode_i;
      else                         result = winner;
   end

   // R1, R2: registered result with one-cycle valid
   logic              vld_q;
   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         vld_q <= req_i;
         if (req_i) mode_q <= result;
      end
   end

   assign vld_o  = vld_q;
   assign mode_o = mode_q;

   // R2
   vld_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> vld_o);

   // R2
   vld_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !vld_o);

   // R2
   mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> $stable(mode_o));

   // R9
   clamp_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> mode_o <= $past(req_mode_i));

   // R10
   inhibit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && non_disk_i && host_no_atapi_dma_i |=> mode_o == 8'h00);

   // R6
   cable_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && !cable_ok_i |=> mode_o <= CUT_CEIL);

endmodule

// File: tb/dma_mode_sel_tb.sv
module dma_mode_sel_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [7:0] req_mode = '0;
   logic [2:0] valid = '0;
   logic [6:0] d_u = '0, h_u = '0;
   logic [2:0] d_m = '0, h_m = '0, d_s = '0, h_s = '0;
   logic [7:0] leg = '0;
   logic       cable = 1'b0, nd = 1'b0, inh = 1'b0;
   logic       vld;
   logic [7:0] mode;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_mode_sel dut_i (
      .clk_i               (clk),
      .rst_ni              (rst_n),
      .req_i               (req),
      .req_mode_i          (req_mode),
      .id_valid_i          (valid),
      .drv_udma_i          (d_u),
      .drv_mword_i         (d_m),
      .drv_sword_i         (d_s),
      .drv_legacy_i        (leg),
      .host_udma_i         (h_u),
      .host_mword_i        (h_m),
      .host_sword_i        (h_s),
      .cable_ok_i          (cable),
      .non_disk_i          (nd),
      .host_no_atapi_dma_i (inh),
      .vld_o               (vld),
      .mode_o              (mode)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   function automatic int top_bit(input int m);
      int r = -1;
      for (int i = 0; i < 16; i++) if (m[i]) r = i;
      return r;
   endfunction

   // Independent model of the selection rules
   function automatic int model();
      int um, mm, sm, sel, rq;
      rq = int'(req_mode);
      um = valid[2] ? int'(h_u & d_u) : 0;
      if (rq > 'h42 && (um & 'h78) != 0 && !cable) um = um & 7;
      mm = valid[1] ? int'(h_m & d_m) : 0;
      if (valid[1]) sm = int'(h_s & d_s);
      else if (int'(leg) <= 2) sm = ((2 << int'(leg)) - 1) & int'(h_s);
      else sm = 0;
      sel = 0;
      if (rq >= 'h40 && um != 0) sel = 'h40 + top_bit(um);
      else if (rq >= 'h20 && mm != 0) sel = 'h20 + top_bit(mm);
      else if (rq >= 'h10 && sm != 0) sel = 'h10 + top_bit(sm);
      if (nd && inh) return 0;
      return (sel > rq) ? rq : sel;
   endfunction

   task automatic set_in(input int rq, input int v, input int du, input int hu,
                         input int dm, input int hm, input int ds, input int hs,
                         input int lg, input bit cb, input bit n, input bit ih);
      req_mode = 8'(rq); valid = 3'(v);
      d_u = 7'(du); h_u = 7'(hu); d_m = 3'(dm); h_m = 3'(hm);
      d_s = 3'(ds); h_s = 3'(hs); leg = 8'(lg);
      cable = cb; nd = n; inh = ih;
   endtask

   // Strobe once, sample the result one negedge later
   task automatic txn(input string tag, input int exp);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk({tag, " valid"}, int'(vld), 1);
      chk(tag, int'(mode), exp);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'h5eed_d3a1);
      repeat (3) @(negedge clk);
      // R1
      chk("R1 reset valid", int'(vld), 0);
      chk("R1 reset mode", int'(mode), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", int'(mode), 0);

      // R7 full Ultra
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R7 ultra top", 'h46);
      // R3 host AND drive
      set_in('h46, 6, 'h1f, 'h07, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R3 ultra and", 'h42);
      // R3 validity bit 2 clear
      set_in('h46, 2, 'h7f, 'h7f, 7, 3, 7, 7, 0, 1, 0, 0);
      txn("R3 ultra invalid", 'h21);
      // R4 validity bit 1 clear, legacy too large
      set_in('h46, 4, 0, 'h7f, 7, 7, 7, 7, 7, 1, 0, 0);
      txn("R4 word invalid", 'h00);
      // R4 single-word word used
      set_in('h46, 2, 0, 0, 0, 7, 3, 7, 0, 1, 0, 0);
      txn("R4 sword word", 'h11);
      // R5 legacy
      set_in('h46, 0, 0, 0, 0, 0, 0, 7, 1, 1, 0, 0);
      txn("R5 legacy 1", 'h11);
      set_in('h46, 0, 0, 0, 0, 0, 0, 5, 2, 1, 0, 0);
      txn("R5 legacy host and", 'h12);
      set_in('h46, 0, 0, 0, 0, 0, 0, 7, 3, 1, 0, 0);
      txn("R5 legacy 3", 'h00);
      // R6 cable
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 0, 0, 0);
      txn("R6 cut", 'h42);
      set_in('h43, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 0, 0, 0);
      txn("R6 cut 43", 'h42);
      set_in('h43, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R6 good cable", 'h43);
      set_in('h42, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 0, 0, 0);
      txn("R6 no cut at 42", 'h42);
      set_in('h46, 6, 'h78, 'h7f, 7, 7, 7, 7, 0, 0, 0, 0);
      txn("R6 cut to empty", 'h22);
      // R8 skipping
      set_in('h22, 6, 'h7f, 'h7f, 1, 1, 7, 7, 0, 1, 0, 0);
      txn("R8 skip ultra", 'h20);
      set_in('h15, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R8 skip two", 'h12);
      set_in('h0f, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R8 skip all", 'h00);
      // R9 clamp
      set_in('h41, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R9 clamp", 'h41);
      set_in('h30, 6, 0, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R9 no clamp", 'h22);
      // R10 inhibit
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 1, 1);
      txn("R10 inhibit", 'h00);
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 1, 0);
      txn("R10 non-disk allowed", 'h46);
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 1);
      txn("R10 disk", 'h46);
      // R11 empty
      set_in('h46, 6, 'h7f, 0, 7, 0, 7, 0, 0, 1, 0, 0);
      txn("R11 none", 'h00);
      // R2 hold without strobe
      set_in('h46, 6, 'h7f, 'h7f, 7, 7, 7, 7, 0, 1, 0, 0);
      txn("R2 load", 'h46);
      set_in('h20, 2, 0, 0, 1, 1, 1, 1, 0, 1, 0, 0);
      repeat (3) @(negedge clk);
      chk("R2 idle valid", int'(vld), 0);
      chk("R2 hold", int'(mode), 'h46);

      // Random patterns against the model (R7 and all rules)
      for (int k = 0; k < 3000; k++) begin
         int rq;
         case ($urandom_range(0, 3))
            0: rq = $urandom_range('h40, 'h47);
            1: rq = $urandom_range('h1e, 'h24);
            2: rq = $urandom_range('h0e, 'h14);
            default: rq = $urandom_range(0, 'hff);
         endcase
         set_in(rq, $urandom_range(0, 7), $urandom_range(0, 'h7f),
                $urandom_range(0, 'h7f), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 4),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
         txn("R7 random", model());
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule